// File: doc/BRIEF.md
# Software Command Read-Sequence Detector

This block watches the chip-select, write and store-request pins of a non-volatile SRAM. It looks for two software commands that are hidden in ordinary read traffic. Each command is an exact run of six reads at fixed addresses. When the recall run completes, the block raises a one-cycle request to the store/recall sequencer. A second table, which is a parameter, recognizes the store command and raises its own one-cycle request.

The block only observes the bus. The read data path is never touched, so the first five reads of a command are ordinary reads. Each access is counted once, on the clock where chip select is first seen high. A read at a wrong address, a write, or an access made while the store pin is asserted breaks the run. While the sequencer reports busy, the detector ignores the bus and stays idle.

Top module: `swcmd_seq_detect`

## Requirements
- R1: Six counted reads at addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0C63, in that order, drive `recall_go` high for exactly one clock. That clock is the one after the sampling edge where `cs_en` is first seen high for the sixth read.
- R2: Any run of fewer than six matching reads leaves both `recall_go` and `store_go` low.
- R3: Only address bits 13:0 are compared, so the value of bit 14 has no effect on matching.
- R4: A counted read at an address other than the next expected one abandons the run. If that address equals the first table entry, the run restarts at step one; otherwise it returns to idle.
- R5: An access counted with `wr_req`=1, or with `hold_req`=1, returns the run to idle.
- R6: An access is counted only on a rising edge of `cs_en` (sampled high after being low). Address changes while `cs_en` stays high are not counted.
- R7: Six counted reads at the store table entries drive `store_go` high for one clock. The default entries are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0. Each command pulses only its own output.
- R8: While `seq_busy`=1, no access is counted and any partial run is cleared to idle.
- R9: While `rst_n` is low, and in the first clock after reset, both pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_en | input | 1 | Chip select asserted (active high) |
| wr_req | input | 1 | Write-enable asserted (active high) |
| hold_req | input | 1 | Hardware store pin asserted (active high) |
| addr | input | 15 | Bus address |
| seq_busy | input | 1 | Store/recall sequencer busy |
| recall_go | output | 1 | One-cycle recall request |
| store_go | output | 1 | One-cycle store request |

## Verification
The bench runs the two complete commands, and the recall command with bit 14 set. These runs separate correct matching from a design that compares all fifteen bits or that shares one pulse between both tables. It then runs broken patterns: a stray address, the first entry repeated in the middle of a run, a write, and a store-pin access. These separate a restart at step one from a plain reset to idle. A run made while chip select stays high, and runs made around a busy window, show that only select edges count and that busy clears progress rather than freezing it.

// File: rtl/swcmd_pkg.sv
// Package: shared sizes, table type and default command tables for the
// software command detector. Entry 0 of a table is the first read expected.
package swcmd_pkg;
    parameter int CMP_W   = 14;
    parameter int SEQ_LEN = 6;

    typedef logic [CMP_W-1:0]               cmd_addr_t;
    typedef logic [SEQ_LEN-1:0][CMP_W-1:0]  cmd_tab_t;

    parameter cmd_tab_t RECALL_TAB_DEF = {14'h0C63, 14'h303F, 14'h3C1F,
                                          14'h03E0, 14'h31C7, 14'h0E38};
    parameter cmd_tab_t STORE_TAB_DEF  = {14'h0FC0, 14'h303F, 14'h3C1F,
                                          14'h03E0, 14'h31C7, 14'h0E38};
endpackage

// File: rtl/swcmd_access_edge.sv
// Module: swcmd_access_edge
// Turns the level chip-select into one access event per rising edge and
// classifies the event as a valid read or as any other access.
// Assumes bus pins are already synchronous to clk.
module swcmd_access_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_en,
    input  logic wr_req,
    input  logic hold_req,
    input  logic mask,
    output logic rd_evt,
    output logic other_evt
);
    logic cs_q;
    logic acc_evt;

    // Remember the previous select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_en;
    end

    // Classify the access that starts this cycle, if any.
    always_comb begin
        acc_evt   = cs_en && !cs_q && !mask;
        rd_evt    = acc_evt && !wr_req && !hold_req;
        other_evt = acc_evt && (wr_req || hold_req);
    end
endmodule

// File: rtl/swcmd_seq_match.sv
// Module: swcmd_seq_match
// Tracks progress through one SEQ_LEN-entry address table and emits a
// one-cycle hit after the last entry. A wrong read restarts at step one if it
// equals entry 0, else returns to idle; other accesses and clr return to idle.
module swcmd_seq_match #(
    parameter swcmd_pkg::cmd_tab_t TABLE = swcmd_pkg::RECALL_TAB_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 rd_evt,
    input  logic                 other_evt,
    input  swcmd_pkg::cmd_addr_t cmp_addr,
    output logic                 hit
);
    localparam int STEP_W = $clog2(swcmd_pkg::SEQ_LEN);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(swcmd_pkg::SEQ_LEN - 1);

    logic [STEP_W-1:0] step;
    logic              exp_hit;
    logic              first_hit;

    // Compare the bus address with the expected and the first entries.
    always_comb begin
        exp_hit   = (cmp_addr == TABLE[step]);
        first_hit = (cmp_addr == TABLE[0]);
    end

    // Advance, restart or clear the step counter; pulse on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
            hit  <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (clr || other_evt) begin
                step <= '0;
            end else if (rd_evt) begin
                if (exp_hit) begin
                    if (step == LAST) begin
                        step <= '0;
                        hit  <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end else if (first_hit) begin
                    step <= STEP_W'(1);
                end else begin
                    step <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/swcmd_seq_detect.sv
// Module: swcmd_seq_detect (top)
// Detects the software recall and store commands embedded in read traffic
// and pulses one request per completed command. Observes the bus only.
// Assumes ADDR_W >= swcmd_pkg::CMP_W; upper address bits are ignored.
module swcmd_seq_detect #(
    parameter int                  ADDR_W     = 15,
    parameter swcmd_pkg::cmd_tab_t RECALL_TAB = swcmd_pkg::RECALL_TAB_DEF,
    parameter swcmd_pkg::cmd_tab_t STORE_TAB  = swcmd_pkg::STORE_TAB_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_en,
    input  logic              wr_req,
    input  logic              hold_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              seq_busy,
    output logic              recall_go,
    output logic              store_go
);
    localparam int NUM_CMD = 2;

    logic                 rd_evt;
    logic                 other_evt;
    swcmd_pkg::cmd_addr_t cmp_addr;
    logic [NUM_CMD-1:0]   hits;

    // Keep only the compared address bits.
    always_comb cmp_addr = addr[swcmd_pkg::CMP_W-1:0];

    swcmd_access_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_en     (cs_en),
        .wr_req    (wr_req),
        .hold_req  (hold_req),
        .mask      (seq_busy),
        .rd_evt    (rd_evt),
        .other_evt (other_evt)
    );

    // One matcher per command table; index 0 is recall, 1 is store.
    for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
        swcmd_seq_match #(
            .TABLE (g == 0 ? RECALL_TAB : STORE_TAB)
        ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (seq_busy),
            .rd_evt    (rd_evt),
            .other_evt (other_evt),
            .cmp_addr  (cmp_addr),
            .hit       (hits[g])
        );
    end

    assign recall_go = hits[0];
    assign store_go  = hits[1];
endmodule

// File: rtl/swcmd_seq_detect_chk.sv
// Module: swcmd_seq_detect_chk
// Assertion checker bound to swcmd_seq_detect; observes ports only.
module swcmd_seq_detect_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_en,
    input logic              wr_req,
    input logic              hold_req,
    input logic [ADDR_W-1:0] addr,
    input logic              seq_busy,
    input logic              recall_go,
    input logic              store_go
);
    AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |=> !recall_go); // R1
    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> !store_go); // R7
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(recall_go && store_go)); // R7
    AST_RECALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |-> ($past(cs_en) && !$past(wr_req) && !$past(hold_req))); // R5
    AST_STORE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> ($past(cs_en) && !$past(wr_req) && !$past(hold_req))); // R5
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> (!recall_go && !store_go)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!recall_go && !store_go)); // R9
endmodule

bind swcmd_seq_detect swcmd_seq_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_en     (cs_en),
    .wr_req    (wr_req),
    .hold_req  (hold_req),
    .addr      (addr),
    .seq_busy  (seq_busy),
    .recall_go (recall_go),
    .store_go  (store_go)
);

// File: tb/swcmd_seq_detect_test.sv
// Directed bench for swcmd_seq_detect: one task per scenario.
module swcmd_seq_detect_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_en = 1'b0;
    logic        wr_req = 1'b0;
    logic        hold_req = 1'b0;
    logic [14:0] addr = '0;
    logic        seq_busy = 1'b0;
    logic        recall_go;
    logic        store_go;

    int n_chk = 0;
    int n_bad = 0;
    int rec_cnt;
    int sto_cnt;

    logic [14:0] rcl [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63};
    logic [14:0] sto [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};

    swcmd_seq_detect uut (
        .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .wr_req(wr_req),
        .hold_req(hold_req), .addr(addr), .seq_busy(seq_busy),
        .recall_go(recall_go), .store_go(store_go)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pulse counters sampled at negedges.
    always @(negedge clk) begin
        if (recall_go) rec_cnt++;
        if (store_go)  sto_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        rec_cnt = 0;
        sto_cnt = 0;
    endtask

    // One access: select for one clock, then deselect for one clock.
    task automatic access(input logic [14:0] a, input logic w, input logic h);
        @(negedge clk);
        addr = a; wr_req = w; hold_req = h; cs_en = 1'b1;
        @(negedge clk);
        cs_en = 1'b0; wr_req = 1'b0; hold_req = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a);
        access(a, 1'b0, 1'b0);
    endtask

    task automatic rd_seq(input logic [14:0] t [6], input int from, input int upto,
                          input logic [14:0] orv);
        for (int i = from; i <= upto; i++) rd(t[i] | orv);
    endtask

    task automatic t_reset();
        chk("R9 recall_go in reset", int'(recall_go), 0);
        chk("R9 store_go in reset", int'(store_go), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9 recall_go after reset", int'(recall_go), 0);
        chk("R9 store_go after reset", int'(store_go), 0);
    endtask

    task automatic t_recall();
        clear_counts();
        for (int i = 0; i < 5; i++) rd(rcl[i]);
        chk("R2 five reads no recall", rec_cnt, 0);
        @(negedge clk);
        addr = rcl[5]; cs_en = 1'b1;
        @(negedge clk);
        chk("R1 recall_go after sixth read", int'(recall_go), 1);
        cs_en = 1'b0;
        @(negedge clk);
        chk("R1 recall_go one cycle", int'(recall_go), 0);
        chk("R1 recall count", rec_cnt, 1);
        chk("R7 recall gives no store", sto_cnt, 0);
    endtask

    task automatic t_store();
        clear_counts();
        rd_seq(sto, 0, 5, 15'h0);
        @(negedge clk);
        chk("R7 store count", sto_cnt, 1);
        chk("R7 store gives no recall", rec_cnt, 0);
    endtask

    task automatic t_bit14();
        clear_counts();
        rd_seq(rcl, 0, 5, 15'h4000);
        @(negedge clk);
        chk("R3 bit14 ignored", rec_cnt, 1);
    endtask

    task automatic t_wrong();
        clear_counts();
        rd_seq(rcl, 0, 2, 15'h0);
        rd(15'h1234);
        rd_seq(rcl, 3, 5, 15'h0);
        @(negedge clk);
        chk("R4 stray address resets", rec_cnt, 0);
        clear_counts();
        rd_seq(rcl, 0, 3, 15'h0);
        rd(rcl[0]);
        rd_seq(rcl, 1, 5, 15'h0);
        @(negedge clk);
        chk("R4 first entry restarts at step one", rec_cnt, 1);
    endtask

    task automatic t_write();
        clear_counts();
        rd_seq(rcl, 0, 2, 15'h0);
        access(rcl[3], 1'b1, 1'b0);
        rd_seq(rcl, 3, 5, 15'h0);
        @(negedge clk);
        chk("R5 write resets", rec_cnt, 0);
        clear_counts();
        rd_seq(rcl, 0, 2, 15'h0);
        access(rcl[3], 1'b0, 1'b1);
        rd_seq(rcl, 4, 5, 15'h0);
        @(negedge clk);
        chk("R5 store pin access resets", rec_cnt, 0);
    endtask

    task automatic t_hold_select();
        clear_counts();
        @(negedge clk);
        addr = rcl[0]; cs_en = 1'b1;
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            addr = rcl[i];
        end
        @(negedge clk);
        cs_en = 1'b0;
        chk("R6 held select counts once", rec_cnt, 0);
        rd_seq(rcl, 1, 5, 15'h0);
        @(negedge clk);
        chk("R6 progress was step one", rec_cnt, 1);
    endtask

    task automatic t_busy();
        clear_counts();
        rd_seq(rcl, 0, 2, 15'h0);
        @(negedge clk); seq_busy = 1'b1;
        @(negedge clk); seq_busy = 1'b0;
        rd_seq(rcl, 3, 5, 15'h0);
        @(negedge clk);
        chk("R8 busy clears progress", rec_cnt, 0);
        clear_counts();
        seq_busy = 1'b1;
        rd_seq(rcl, 0, 5, 15'h0);
        rd_seq(sto, 0, 5, 15'h0);
        @(negedge clk);
        chk("R8 no recall while busy", rec_cnt, 0);
        chk("R8 no store while busy", sto_cnt, 0);
        seq_busy = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rec_cnt = 0; sto_cnt = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_recall();
        t_store();
        t_bit14();
        t_wrong();
        t_write();
        t_hold_select();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule